// File: doc/BRIEF.md
# Video Line Data Block Capture

This block watches one chosen line of a video frame for a burst of data clock pulses carrying a 72-bit block. When a complete burst arrives it stores the bits in nine byte registers. It also measures two durations in pixel clocks and stores them: the width of the horizontal sync pulse during vertical blanking, and the length of the data window on the chosen line. A status flag then holds every stored value until host software has read them. The host reads a byte-wide register port. Reading the shadow control byte after the window group has been read lowers the flag, and capture is armed again at the next vertical sync.

The host picks the line with a line-number input. A two-bit mode register sets two things: whether a burst is accepted only during vertical blanking, and whether capture runs in every frame or only in odd fields of an interlaced picture. All inputs are taken as synchronous to the pixel clock.

Top module: `vline_capture`

## Requirements
- R1: A burst of exactly 72 rising edges of `dclk_i` on the selected line is committed at the hsync rising edge that ends the line. Commit sets `stat_o`. The bit sampled with the first edge lands in byte 0 bit 0, and bits follow LSB first. Data byte k reads at address 4+k.
- R2: A line that carries fewer than 72 or more than 72 data clock edges commits nothing, and `stat_o` stays 0.
- R3: The hsync width is the number of clocks with `hsync_i` high. It is latched at the falling edge of hsync while `vblank_i` is high and capture is armed. Address 0 returns bits 7..0 and address 1 returns bits 9..8 in its bits 1..0. The value saturates at 1023.
- R4: The window length is the number of clocks from the first to the 72nd data clock edge, both included. Address 2 returns bits 7..0 and address 3 returns bits 10..8 in its bits 2..0. The value saturates at 2047.
- R5: Mode bit 1 is the limit bit and resets to 1. When it is 1, a burst is accepted only if `vblank_i` is high at its 72nd edge. When it is 0, a burst in active video is accepted as well.
- R6: While `stat_o` is 1, no stored duration or data byte changes.
- R7: A read of address 13 returns {stat, 5'b0, limit, interlace}. It clears `stat_o` only if addresses 0 to 5 have each been read since the capture.
- R8: When the flag clears, both durations read 0. No hsync measurement is made until the next rising edge of vsync.
- R9: Mode bit 0 selects interlace. A field bit is even at reset and toggles at each vsync rising edge. With interlace set to 1, capture happens only in odd fields.
- R10: After reset, `stat_o` is 0 and every address reads 0, except address 13, which reads 8'h02. Addresses 14 and 15 always read 0.
- R11: A vsync rising edge clears the line count, and each hsync rising edge advances it. A burst counts only on the line whose number equals `sel_line_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| vblank_i | input | 1 | High during vertical blanking |
| dclk_i | input | 1 | Data clock; bits are taken on its rising edges |
| dat_i | input | 1 | Serial data bit |
| sel_line_i | input | LINE_W | Number of the line to watch |
| mode_wr_i | input | 1 | Load strobe for the mode register |
| mode_i | input | 2 | Mode value: bit 1 limit, bit 0 interlace |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register byte address |
| rd_data_o | output | 8 | Read data, combinational from the address |
| stat_o | output | 1 | Status flag: stored values are frozen |

## Verification
The bench builds the block with its default parameters: a 10-bit sync width, an 11-bit window, nine data bytes, an 11-bit line number and a 4-bit address. It selects line 3. These sizes keep a whole frame within a few thousand clocks. A 1100-clock sync pulse and a data clock spaced at 30 clocks are then enough to reach both saturation limits. Nine bytes fill addresses 4 to 12 and leave 14 and 15 unused, so the zero return of unused addresses can be checked.

// File: rtl/vlc_pkg.sv
`timescale 1ns/1ps
package vlc_pkg;
   // First data byte address; durations occupy the addresses below it
   localparam int unsigned A_DAT0  = 4;
   // Number of leading addresses that must be read before the flag can clear
   localparam int unsigned GROUP_N = 6;

   typedef struct packed {
      logic limit;
      logic interlace;
   } mode_t;
endpackage

// File: rtl/vlc_sat_cnt.sv
`timescale 1ns/1ps
module vlc_sat_cnt #(
   parameter int unsigned W        = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] MAXV = '1;

   logic [W-1:0] cnt_q;
   logic [W-1:0] step;

   generate
      if (SATURATE) begin : g_sat
         assign step = (cnt_q == MAXV) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign step = cnt_q + 1'b1;
      end
   endgenerate

   // clear with a simultaneous increment loads one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= inc_i ? W'(1) : '0;
      else if (inc_i) cnt_q <= step;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/vlc_burst.sv
`timescale 1ns/1ps
module vlc_burst #(
   parameter int unsigned NBITS = 72,
   parameter int unsigned WIN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             en_i,
   input  logic             edge_i,
   input  logic             dat_i,
   input  logic             vblank_i,
   output logic             complete_o,
   output logic             blank_o,
   output logic [WIN_W-1:0] win_o,
   output logic [NBITS-1:0] bits_o
);
   localparam int unsigned PCNT_W = $clog2(NBITS + 2);
   localparam logic [PCNT_W-1:0] P_FULL = PCNT_W'(NBITS);
   localparam logic [PCNT_W-1:0] P_LAST = PCNT_W'(NBITS - 1);

   logic [PCNT_W-1:0] pcnt;
   logic              take;
   logic              first;
   logic              win_inc;
   logic [NBITS-1:0]  sr_q;
   logic              blank_q;

   assign take    = en_i && edge_i;
   assign first   = take && (restart_i || pcnt == '0);
   assign win_inc = first || (!restart_i && pcnt != '0 && pcnt < P_FULL);

   vlc_sat_cnt #(.W(PCNT_W), .SATURATE(1'b1)) i_pulse_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (restart_i),
      .inc_i (take),
      .cnt_o (pcnt)
   );

   vlc_sat_cnt #(.W(WIN_W), .SATURATE(1'b1)) i_win_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (first),
      .inc_i (win_inc),
      .cnt_o (win_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else if (take) sr_q <= {dat_i, sr_q[NBITS-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              blank_q <= 1'b0;
      else if (restart_i)                      blank_q <= 1'b0;
      else if (take && pcnt == P_LAST)         blank_q <= vblank_i;
   end

   assign complete_o = (pcnt == P_FULL);
   assign blank_o    = blank_q;
   assign bits_o     = sr_q;
endmodule

// File: rtl/vlc_regs.sv
`timescale 1ns/1ps
module vlc_regs
   import vlc_pkg::*;
#(
   parameter int unsigned HSW_W  = 10,
   parameter int unsigned WIN_W  = 11,
   parameter int unsigned NBYTES = 9,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hsw_ld_i,
   input  logic [HSW_W-1:0]      hsw_i,
   input  logic                  commit_i,
   input  logic [WIN_W-1:0]      win_i,
   input  logic [NBYTES*8-1:0]   data_i,
   input  logic                  mode_wr_i,
   input  logic [1:0]            mode_i,
   input  logic                  rd_en_i,
   input  logic [ADDR_W-1:0]     rd_addr_i,
   output logic [7:0]            rd_data_o,
   output logic                  stat_o,
   output mode_t                 mode_o,
   output logic                  all_read_o,
   output logic [HSW_W-1:0]      hsw_o,
   output logic [WIN_W-1:0]      win_o,
   output logic [NBYTES*8-1:0]   data_o
);
   localparam int unsigned SHADOW = A_DAT0 + NBYTES;
   localparam int unsigned NREG   = SHADOW + 1;

   logic [HSW_W-1:0]    hsw_q;
   logic [WIN_W-1:0]    win_q;
   logic [NBYTES*8-1:0] data_q;
   logic                stat_q;
   mode_t               mode_q;
   logic [GROUP_N-1:0]  rd_mask;
   logic                shadow_rd;
   logic                clr;
   logic [15:0]         hsw_ext;
   logic [15:0]         win_ext;
   logic [7:0]          bank [NREG];

   assign shadow_rd  = rd_en_i && rd_addr_i == ADDR_W'(SHADOW);
   assign all_read_o = &rd_mask;
   assign clr        = shadow_rd && stat_q && all_read_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q <= 1'b0;
      else if (commit_i) stat_q <= 1'b1;
      else if (clr)      stat_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hsw_q <= '0;
      else if (clr)                 hsw_q <= '0;
      else if (hsw_ld_i && !stat_q) hsw_q <= hsw_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         data_q <= '0;
      end else if (commit_i && !stat_q) begin
         win_q  <= win_i;
         data_q <= data_i;
      end else if (clr) begin
         win_q  <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= '{limit: 1'b1, interlace: 1'b0};
      else if (mode_wr_i) mode_q <= '{limit: mode_i[1], interlace: mode_i[0]};
   end

   // one sticky bit per address of the read-before-clear group
   for (genvar g = 0; g < GROUP_N; g++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  rd_mask[g] <= 1'b0;
         else if (commit_i || clr)    rd_mask[g] <= 1'b0;
         else if (rd_en_i && stat_q && rd_addr_i == ADDR_W'(g))
                                      rd_mask[g] <= 1'b1;
      end
   end

   assign hsw_ext = 16'(hsw_q);
   assign win_ext = 16'(win_q);

   assign bank[0] = hsw_ext[7:0];
   assign bank[1] = hsw_ext[15:8];
   assign bank[2] = win_ext[7:0];
   assign bank[3] = win_ext[15:8];
   for (genvar b = 0; b < NBYTES; b++) begin : g_bank
      assign bank[A_DAT0 + b] = data_q[8*b +: 8];
   end
   assign bank[SHADOW] = {stat_q, 5'b0, mode_q.limit, mode_q.interlace};

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NREG; k++) begin
         if (rd_addr_i == ADDR_W'(k)) rd_data_o = bank[k];
      end
   end

   assign stat_o = stat_q;
   assign mode_o = mode_q;
   assign hsw_o  = hsw_q;
   assign win_o  = win_q;
   assign data_o = data_q;
endmodule

// File: rtl/vline_capture.sv
`timescale 1ns/1ps
module vline_capture
   import vlc_pkg::*;
#(
   parameter int unsigned HSW_W  = 10,
   parameter int unsigned WIN_W  = 11,
   parameter int unsigned NBYTES = 9,
   parameter int unsigned LINE_W = 11,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_i,
   input  logic              vsync_i,
   input  logic              vblank_i,
   input  logic              dclk_i,
   input  logic              dat_i,
   input  logic [LINE_W-1:0] sel_line_i,
   input  logic              mode_wr_i,
   input  logic [1:0]        mode_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              stat_o
);
   localparam int unsigned NBITS = NBYTES * 8;

   initial begin : p_param_chk
      if (HSW_W <= 8 || HSW_W > 16) $fatal(1, "HSW_W must be 9..16");
      if (WIN_W <= 8 || WIN_W > 16) $fatal(1, "WIN_W must be 9..16");
      if (NBYTES < 1) $fatal(1, "NBYTES must be at least 1");
      if (A_DAT0 + NBYTES + 1 > (1 << ADDR_W)) $fatal(1, "ADDR_W too small");
      if (GROUP_N > A_DAT0 + NBYTES) $fatal(1, "read group exceeds map");
   end

   logic [2:0]        sync_q;
   logic              hs_rise, hs_fall, vs_rise, dc_rise;
   logic [LINE_W-1:0] line_cnt;
   logic              line_sel;
   logic              field_q;
   logic              field_ok;
   logic              meas_en;
   logic [HSW_W-1:0]  hs_cnt;
   logic              burst_done;
   logic              burst_blank;
   logic [WIN_W-1:0]  burst_win;
   logic [NBITS-1:0]  burst_bits;
   logic              commit;
   logic              all_read;
   mode_t             mode;
   logic [HSW_W-1:0]  hsw_q;
   logic [WIN_W-1:0]  win_q;
   logic [NBITS-1:0]  data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {hsync_i, vsync_i, dclk_i};
   end

   assign hs_rise = hsync_i  && !sync_q[2];
   assign hs_fall = !hsync_i && sync_q[2];
   assign vs_rise = vsync_i  && !sync_q[1];
   assign dc_rise = dclk_i   && !sync_q[0];

   vlc_sat_cnt #(.W(LINE_W), .SATURATE(1'b1)) i_line_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (vs_rise),
      .inc_i (hs_rise),
      .cnt_o (line_cnt)
   );

   assign line_sel = (line_cnt == sel_line_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       field_q <= 1'b0;
      else if (vs_rise) field_q <= ~field_q;
   end

   assign field_ok = !mode.interlace || field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  meas_en <= 1'b0;
      else if (commit)             meas_en <= 1'b0;
      else if (vs_rise && !stat_o) meas_en <= 1'b1;
   end

   vlc_sat_cnt #(.W(HSW_W), .SATURATE(1'b1)) i_hs_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (!hsync_i),
      .inc_i (hsync_i),
      .cnt_o (hs_cnt)
   );

   vlc_burst #(.NBITS(NBITS), .WIN_W(WIN_W)) i_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (hs_rise),
      .en_i       (line_sel),
      .edge_i     (dc_rise),
      .dat_i      (dat_i),
      .vblank_i   (vblank_i),
      .complete_o (burst_done),
      .blank_o    (burst_blank),
      .win_o      (burst_win),
      .bits_o     (burst_bits)
   );

   assign commit = hs_rise && line_sel && burst_done && field_ok && meas_en &&
                   !stat_o && (burst_blank || !mode.limit);

   vlc_regs #(
      .HSW_W  (HSW_W),
      .WIN_W  (WIN_W),
      .NBYTES (NBYTES),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsw_ld_i   (hs_fall && vblank_i && meas_en),
      .hsw_i      (hs_cnt),
      .commit_i   (commit),
      .win_i      (burst_win),
      .data_i     (burst_bits),
      .mode_wr_i  (mode_wr_i),
      .mode_i     (mode_i),
      .rd_en_i    (rd_en_i),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_data_o),
      .stat_o     (stat_o),
      .mode_o     (mode),
      .all_read_o (all_read),
      .hsw_o      (hsw_q),
      .win_o      (win_q),
      .data_o     (data_q)
   );
endmodule

// File: rtl/vlc_check.sv
`timescale 1ns/1ps
module vlc_check #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned HSW_W  = 10,
   parameter int unsigned WIN_W  = 11,
   parameter int unsigned NBITS  = 72,
   parameter int unsigned SHADOW = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hsync_i,
   input logic              rd_en_i,
   input logic [ADDR_W-1:0] rd_addr_i,
   input logic              stat_o,
   input logic              all_read,
   input logic [HSW_W-1:0]  hsw_q,
   input logic [WIN_W-1:0]  win_q,
   input logic [NBITS-1:0]  data_q
);
   // R1: the flag rises only right after an hsync rising edge
   a_r1_commit_at_hsync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o) |-> ($past(hsync_i) && !$past(hsync_i, 2)));

   // R6: stored values hold while frozen and no shadow read is made
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o && !(rd_en_i && rd_addr_i == ADDR_W'(SHADOW)))
      |=> ($stable(hsw_q) && $stable(win_q) && $stable(data_q)));

   // R7: the flag falls only after a shadow read with the full group read
   a_r7_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_o) |-> $past(rd_en_i && rd_addr_i == ADDR_W'(SHADOW) && all_read));

   // R8: both durations are zero once the flag has cleared
   a_r8_zero_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_o) |-> (hsw_q == '0 && win_q == '0));
endmodule

bind vline_capture vlc_check #(
   .ADDR_W (ADDR_W),
   .HSW_W  (HSW_W),
   .WIN_W  (WIN_W),
   .NBITS  (NBYTES * 8),
   .SHADOW (vlc_pkg::A_DAT0 + NBYTES)
) i_vlc_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .hsync_i   (hsync_i),
   .rd_en_i   (rd_en_i),
   .rd_addr_i (rd_addr_i),
   .stat_o    (stat_o),
   .all_read  (all_read),
   .hsw_q     (hsw_q),
   .win_q     (win_q),
   .data_q    (data_q)
);

// File: tb/test_vline_capture.sv
`timescale 1ns/1ps
module test_vline_capture;
   localparam int SEL = 3;
   localparam logic [71:0] D1 = 72'hA5_3C_0F_F0_12_34_56_78_9A;
   localparam logic [71:0] D2 = 72'h11_22_33_44_55_66_77_88_99;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync = 1'b0, vsync = 1'b0, vblank = 1'b1, dclk = 1'b0, dat = 1'b0;
   logic [10:0] sel_line = 11'(SEL);
   logic       mode_wr = 1'b0;
   logic [1:0] mode_v = 2'b00;
   logic       rd_en = 1'b0;
   logic [3:0] rd_addr = 4'd0;
   logic [7:0] rd_data;
   logic       stat;

   int n_chk = 0;
   int n_err = 0;
   int nvs = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vline_capture i_vline_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_i    (hsync),
      .vsync_i    (vsync),
      .vblank_i   (vblank),
      .dclk_i     (dclk),
      .dat_i      (dat),
      .sel_line_i (sel_line),
      .mode_wr_i  (mode_wr),
      .mode_i     (mode_v),
      .rd_en_i    (rd_en),
      .rd_addr_i  (rd_addr),
      .rd_data_o  (rd_data),
      .stat_o     (stat)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = 4'(a);
      rd_en   = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input int exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, int'(d), exp);
   endtask

   task automatic stat_chk(input string req, input int exp);
      @(negedge clk);
      chk(req, int'(stat), exp);
   endtask

   task automatic set_mode(input logic [1:0] v);
      @(negedge clk);
      mode_wr = 1'b1;
      mode_v  = v;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic vs_pulse();
      @(negedge clk);
      vsync = 1'b1;
      @(negedge clk);
      vsync = 1'b0;
      nvs++;
   endtask

   task automatic hs_pulse(input int len);
      @(negedge clk);
      hsync = 1'b1;
      repeat (len - 1) @(negedge clk);
      @(negedge clk);
      hsync = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic burst(input int np, input logic [71:0] d, input int gap);
      for (int i = 0; i < np; i++) begin
         @(negedge clk);
         dclk = 1'b1;
         dat  = d[i % 72];
         @(negedge clk);
         dclk = 1'b0;
         repeat (gap - 2) @(negedge clk);
      end
   endtask

   task automatic frame(input int bline, input int np, input logic [71:0] d,
                        input int gap, input bit vb, input int hl);
      vblank = 1'b1;
      vs_pulse();
      for (int ln = 1; ln <= SEL; ln++) begin
         hs_pulse(hl);
         if (ln == bline) begin
            vblank = vb;
            burst(np, d, gap);
            vblank = 1'b1;
         end
      end
      hs_pulse(hl);
      repeat (2) @(negedge clk);
   endtask

   task automatic release_flag();
      logic [7:0] d;
      for (int a = 0; a < 6; a++) rd(a, d);
      rd(13, d);
   endtask

   task automatic t_reset();
      stat_chk("R10 stat after reset", 0);
      for (int a = 0; a < 16; a++)
         rd_chk("R10 reset read", a, (a == 13) ? 8'h02 : 8'h00);
   endtask

   task automatic t_basic();
      frame(SEL, 72, D1, 2, 1'b1, 7);
      stat_chk("R1 flag after capture", 1);
      for (int a = 6; a <= 12; a++)
         rd_chk("R1 data byte", a, int'(D1[8*(a-4) +: 8]));
      rd_chk("R7 shadow value", 13, 8'h82);
      stat_chk("R7 flag held without group reads", 1);
   endtask

   task automatic t_freeze();
      frame(SEL, 72, D2, 2, 1'b1, 9);
      stat_chk("R6 flag still set", 1);
      for (int a = 6; a <= 12; a++)
         rd_chk("R6 data frozen", a, int'(D1[8*(a-4) +: 8]));
   endtask

   task automatic t_clear();
      rd_chk("R3 hsw low", 0, 7);
      rd_chk("R3 hsw high", 1, 0);
      rd_chk("R4 win low", 2, 143);
      rd_chk("R4 win high", 3, 0);
      rd_chk("R1 byte 0", 4, int'(D1[7:0]));
      rd_chk("R1 byte 1", 5, int'(D1[15:8]));
      rd_chk("R7 shadow before clear", 13, 8'h82);
      stat_chk("R7 flag cleared", 0);
      for (int a = 0; a < 4; a++) rd_chk("R8 duration zero", a, 0);
      hs_pulse(12);
      hs_pulse(12);
      rd_chk("R8 no measure before vsync", 0, 0);
   endtask

   task automatic t_bad_count();
      frame(SEL, 71, D2, 2, 1'b1, 5);
      stat_chk("R2 short string rejected", 0);
      frame(SEL, 73, D2, 2, 1'b1, 5);
      stat_chk("R2 long string rejected", 0);
      rd_chk("R3 measure after vsync", 0, 5);
   endtask

   task automatic t_line();
      frame(2, 72, D2, 2, 1'b1, 5);
      stat_chk("R11 other line ignored", 0);
      frame(SEL, 72, D2, 2, 1'b1, 5);
      stat_chk("R11 selected line taken", 1);
      rd_chk("R11 last byte", 12, int'(D2[71:64]));
      release_flag();
      stat_chk("R7 released", 0);
   endtask

   task automatic t_limit();
      frame(SEL, 72, D1, 2, 1'b0, 5);
      stat_chk("R5 active video rejected", 0);
      set_mode(2'b00);
      rd_chk("R7 shadow mode bits", 13, 8'h00);
      frame(SEL, 72, D1, 2, 1'b0, 5);
      stat_chk("R5 active video accepted", 1);
      rd_chk("R5 byte 0", 4, int'(D1[7:0]));
      release_flag();
   endtask

   task automatic t_sat();
      set_mode(2'b10);
      frame(SEL, 72, D1, 30, 1'b1, 1100);
      stat_chk("R4 flag set", 1);
      rd_chk("R3 hsw sat low", 0, 8'hFF);
      rd_chk("R3 hsw sat high", 1, 8'h03);
      rd_chk("R4 win sat low", 2, 8'hFF);
      rd_chk("R4 win sat high", 3, 8'h07);
      release_flag();
   endtask

   task automatic t_interlace();
      set_mode(2'b11);
      for (int f = 0; f < 2; f++) begin
         frame(SEL, 72, D2, 2, 1'b1, 5);
         stat_chk("R9 odd field only", nvs % 2);
         if (stat) release_flag();
      end
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin : p_main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_freeze();
      t_clear();
      t_bad_count();
      t_line();
      t_limit();
      t_sat();
      t_interlace();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule